// File: doc/BRIEF.md
# Prescaled Real-Time Tick Counter

This block is a slow real-time timer. A 32.768 kHz reference arrives as a one-cycle enable pulse, `slowTick`. A programmable prescaler divides those pulses into increment events. Each event advances a free-running 32-bit count, sets a sticky increment flag, and is compared against a software-set alarm value. One level interrupt line is raised from either flag when that flag's enable is set.

Software uses four word registers on a plain read/write strobe bus:

| Word | Offset | Register |
|------|--------|----------|
| 0 | 0x0 | mode |
| 1 | 0x4 | alarm |
| 2 | 0x8 | count |
| 3 | 0xC | flags |

The count register is read-only. Reading the flags register also clears the flags. This makes the usual service routine a single read that returns the pending causes and removes the interrupt.

Top module: `rtt_timer`

## Requirements
- R1: After reset, mode reads 0x00008000 (divide by 32768), alarm reads 0xFFFFFFFF, and count, flags and `irq` are all zero.
- R2: Register selection and read data:
  - `addr[3:2]` selects the word: 0 = mode, 1 = alarm, 2 = count, 3 = flags.
  - `rdata` is combinational from `addr` and is zero whenever `addr[1:0]` is nonzero.
  - Writes to count or flags are ignored.
- R3: The prescaler moves only in cycles with `slowTick` high. While `slowTick` stays low, the count does not change.
- R4: Each increment event happens on the D-th `slowTick` after a restart or after the previous event, where D is the divisor. At that event the count rises by one (wrapping from all ones to zero) and flag bit 1 is set.
- R5: Alarm flag (flag bit 0):
  - It is set at an increment event when the new count equals alarm + 1.
  - It is never set while alarm holds 0xFFFFFFFF.
- R6: `irq` = (flag bit 1 AND mode bit 17) OR (flag bit 0 AND mode bit 16). It follows the flags and the mode bits in the same cycle.
- R7: A read of the flags word returns the current flags in that cycle. The flags and `irq` are clear from the next cycle on.
- R8: If an increment event falls in the same cycle as a flags read, the read returns the old flags and the new event's flags remain set afterwards.
- R9: A mode write:
  - stores `wdata[17:0]`; the other bits read as zero.
  - with bit 18 set, zeroes the count and reloads the prescaler from the new divisor in `wdata[15:0]`. Bit 18 always reads back zero.
- R10: A divisor field of zero divides by 65536.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| slowTick | input | 1 | One-cycle pulse per slow-clock period |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe (only side effect: flag clear) |
| addr | input | 4 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from `addr` |
| irq | output | 1 | Level interrupt |

## Verification
Read data is combinational, so the bench samples `rdata` one time unit after it drives `addr`, within the same cycle. Writes take effect at the next rising edge, and so does the flag clear caused by a read. The bench drives every stimulus at a falling edge and observes at the falling edge that follows, after exactly one register stage.

An increment lands at the rising edge on which `slowTick` meets a prescaler count of zero. After n ticks the bench therefore reads the count once the n-th such edge has passed. Because `irq` is combinational from the flags, it is checked in the same half cycle in which the new flag first becomes visible.

// File: rtl/rtt_pkg.sv
package rtt_pkg;
  typedef struct packed {
    logic incEvt;
    logic restart;
    logic clrStatus;
    logic wrMode;
    logic wrAlarm;
  } rttStrobe_t;

  localparam logic [1:0] SEL_MODE   = 2'd0;
  localparam logic [1:0] SEL_ALARM  = 2'd1;
  localparam logic [1:0] SEL_VALUE  = 2'd2;
  localparam logic [1:0] SEL_STATUS = 2'd3;
endpackage

// File: rtl/rtt_ctrl.sv
module rtt_ctrl
  import rtt_pkg::*;
#(
  parameter int DIV_W     = 16,
  parameter int RESET_DIV = 32768
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             slowTick,
  input  logic             wrEn,
  input  logic             rdEn,
  input  logic [3:0]       addr,
  input  logic             restartBit,
  input  logic [DIV_W-1:0] newDiv,
  input  logic [DIV_W-1:0] curDiv,
  output rttStrobe_t       strobe
);
  localparam logic [DIV_W-1:0] RST_LOAD = DIV_W'(RESET_DIV - 1);

  logic [DIV_W-1:0] preCnt;
  logic             aligned;
  logic [1:0]       wordSel;

  // A zero divisor wraps to all ones, i.e. a full 2^DIV_W division.
  function automatic logic [DIV_W-1:0] loadOf(input logic [DIV_W-1:0] d);
    return d - 1'b1;
  endfunction

  assign aligned = (addr[1:0] == 2'b00);
  assign wordSel = addr[3:2];

  always_comb begin
    strobe.wrMode    = wrEn & aligned & (wordSel == SEL_MODE);
    strobe.wrAlarm   = wrEn & aligned & (wordSel == SEL_ALARM);
    strobe.clrStatus = rdEn & aligned & (wordSel == SEL_STATUS);
    strobe.restart   = strobe.wrMode & restartBit;
    strobe.incEvt    = slowTick & (preCnt == '0) & ~strobe.restart;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCnt <= RST_LOAD;
    end else if (strobe.restart) begin
      preCnt <= loadOf(newDiv);
    end else if (slowTick) begin
      if (preCnt == '0) preCnt <= loadOf(curDiv);
      else              preCnt <= preCnt - 1'b1;
    end
  end
endmodule

// File: rtl/rtt_datapath.sv
module rtt_datapath
  import rtt_pkg::*;
#(
  parameter int DIV_W     = 16,
  parameter int VAL_W     = 32,
  parameter int DATA_W    = 32,
  parameter int RESET_DIV = 32768
) (
  input  logic              clk,
  input  logic              rstN,
  input  rttStrobe_t        strobe,
  input  logic [DATA_W-1:0] wdata,
  input  logic [3:0]        addr,
  output logic [DATA_W-1:0] rdata,
  output logic              irq,
  output logic [DIV_W-1:0]  curDiv,
  output logic [VAL_W-1:0]  valQ,
  output logic [1:0]        statusQ
);
  localparam int MODE_W   = DIV_W + 2;
  localparam int ALM_IE   = DIV_W;
  localparam int INC_IE   = DIV_W + 1;
  localparam logic [MODE_W-1:0] MODE_RST = MODE_W'(RESET_DIV);

  logic [MODE_W-1:0] modeQ;
  logic [VAL_W-1:0]  alarmQ;
  logic [VAL_W-1:0]  nextVal;
  logic              almHit;

  assign curDiv  = modeQ[DIV_W-1:0];
  assign nextVal = valQ + 1'b1;
  assign almHit  = strobe.incEvt & (alarmQ != '1) & (nextVal == alarmQ + 1'b1);
  assign irq     = (statusQ[1] & modeQ[INC_IE]) | (statusQ[0] & modeQ[ALM_IE]);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ   <= MODE_RST;
      alarmQ  <= '1;
      valQ    <= '0;
      statusQ <= '0;
    end else begin
      if (strobe.wrMode)  modeQ  <= wdata[MODE_W-1:0];
      if (strobe.wrAlarm) alarmQ <= wdata[VAL_W-1:0];
      if (strobe.restart)     valQ <= '0;
      else if (strobe.incEvt) valQ <= nextVal;
      statusQ <= (strobe.clrStatus ? 2'b00 : statusQ) | {strobe.incEvt, almHit};
    end
  end

  always_comb begin
    rdata = '0;
    if (addr[1:0] == 2'b00) begin
      unique case (addr[3:2])
        SEL_MODE:   rdata = DATA_W'(modeQ);
        SEL_ALARM:  rdata = DATA_W'(alarmQ);
        SEL_VALUE:  rdata = DATA_W'(valQ);
        SEL_STATUS: rdata = DATA_W'(statusQ);
      endcase
    end
  end
endmodule

// File: rtl/rtt_timer.sv
module rtt_timer
  import rtt_pkg::*;
#(
  parameter int DIV_W     = 16,
  parameter int VAL_W     = 32,
  parameter int DATA_W    = 32,
  parameter int RESET_DIV = 32768
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              slowTick,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [3:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  rttStrobe_t       strobe;
  logic [DIV_W-1:0] curDiv;
  logic [VAL_W-1:0] valQ;
  logic [1:0]       statusQ;

  rtt_ctrl #(.DIV_W(DIV_W), .RESET_DIV(RESET_DIV)) u_ctrl (
    .clk(clk), .rstN(rstN), .slowTick(slowTick), .wrEn(wrEn), .rdEn(rdEn),
    .addr(addr), .restartBit(wdata[DIV_W+2]), .newDiv(wdata[DIV_W-1:0]),
    .curDiv(curDiv), .strobe(strobe)
  );

  rtt_datapath #(.DIV_W(DIV_W), .VAL_W(VAL_W), .DATA_W(DATA_W),
                 .RESET_DIV(RESET_DIV)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wdata(wdata), .addr(addr),
    .rdata(rdata), .irq(irq), .curDiv(curDiv), .valQ(valQ), .statusQ(statusQ)
  );
endmodule

// File: rtl/rtt_checker.sv
module rtt_checker #(
  parameter int DIV_W  = 16,
  parameter int VAL_W  = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic              rdEn,
  input logic [3:0]        addr,
  input logic [DATA_W-1:0] wdata,
  input logic              irq,
  input logic              incEvt,
  input logic [VAL_W-1:0]  valQ,
  input logic [1:0]        statusQ,
  input logic [VAL_W-1:0]  alarmSeen
);
  // R4: the count only steps by one or returns to zero
  a_r4_value_step: assert property (@(posedge clk) disable iff (!rstN)
    (valQ != $past(valQ)) |-> (valQ == $past(valQ) + 1'b1 || valQ == '0));

  // R5: no rising alarm flag while the alarm holds all ones
  a_r5_alarm_off: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusQ[0]) |-> ($past(alarmSeen) != '1));

  // R6: the interrupt needs a pending flag
  a_r6_irq_has_flag: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (statusQ != 2'b00));

  // R7: a flags read with no new event leaves the flags clear
  a_r7_clear_on_read: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == 4'hC && !incEvt) |=> (statusQ == 2'b00));

  // R9: a restart write zeroes the count
  a_r9_restart_zero: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 4'h0 && wdata[DIV_W+2]) |=> (valQ == '0));
endmodule

bind rtt_timer rtt_checker #(.DIV_W(DIV_W), .VAL_W(VAL_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .wdata(wdata),
  .irq(irq), .incEvt(strobe.incEvt), .valQ(valQ), .statusQ(statusQ),
  .alarmSeen(u_dp.alarmQ)
);

// File: tb/tb_rtt_timer.sv
module tb_rtt_timer;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [3:0]  a;
    logic [31:0] w;
    logic [31:0] exp;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{4'h4, 32'h12345678, 32'h12345678},
    '{4'h4, 32'h00000000, 32'h00000000},
    '{4'h0, 32'hFFFBFFFF, 32'h0003FFFF},
    '{4'h0, 32'h00070010, 32'h00030010}
  };

  logic        clk = 0;
  logic        rstN = 0;
  logic        slowTick = 0;
  logic        wrEn = 0;
  logic        rdEn = 0;
  logic [3:0]  addr = 0;
  logic [31:0] wdata = 0;
  logic [31:0] rdata;
  logic        irq;
  int total = 0;
  int bad = 0;
  logic done = 0;

  rtt_timer dut (
    .clk(clk), .rstN(rstN), .slowTick(slowTick), .wrEn(wrEn), .rdEn(rdEn),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1; addr = a; wdata = d;
    @(negedge clk);
    wrEn = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    rdEn = 1; addr = a;
    #1 d = rdata;
    @(negedge clk);
    rdEn = 0;
  endtask

  task automatic tick(input int n);
    @(negedge clk);
    slowTick = 1;
    repeat (n) @(negedge clk);
    slowTick = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rstN = 1;

    // R1 reset values
    rd(4'h0, d); chk("R1 mode", d, 32'h00008000);
    rd(4'h4, d); chk("R1 alarm", d, 32'hFFFFFFFF);
    rd(4'h8, d); chk("R1 value", d, 0);
    rd(4'hC, d); chk("R1 status", d, 0);
    chk("R1 irq", {31'b0, irq}, 0);
    // R2 misaligned offset reads zero
    rd(4'h2, d); chk("R2 unaligned", d, 0);

    // R9 stored mode bits and alarm readback, table driven
    for (int i = 0; i < 4; i++) begin
      wr(VECS[i].a, VECS[i].w);
      rd(VECS[i].a, d);
      chk("R9 readback", d, VECS[i].exp);
    end

    // R4 divide by 3
    wr(4'h4, 32'hFFFFFFFF);
    wr(4'h0, 32'h00040003);
    rd(4'h8, d); chk("R9 restart zeroes", d, 0);
    rd(4'hC, d); rd(4'hC, d); chk("R7 pre-clear", d, 0);
    tick(2); rd(4'h8, d); chk("R4 before terminal", d, 0);
    tick(1); rd(4'h8, d); chk("R4 after terminal", d, 1);
    rd(4'hC, d); chk("R4 inc flag", d, 2);
    rd(4'hC, d); chk("R7 cleared", d, 0);

    // R5 alarm at alarm+1
    wr(4'h4, 32'h2);
    tick(3); rd(4'hC, d); chk("R5 no alarm at value 2", d, 2);
    tick(3); chk("R6 no irq without enable", {31'b0, irq}, 0);
    rd(4'hC, d); chk("R5 alarm at value 3", d, 3);

    // R2 value write ignored
    wr(4'h8, 32'h55); rd(4'h8, d); chk("R2 value read-only", d, 3);
    // R3 idle
    repeat (20) @(negedge clk);
    rd(4'h8, d); chk("R3 no tick no change", d, 3);

    // R9 restart mid-count reloads prescaler
    tick(2);
    wr(4'h0, 32'h00040003);
    tick(2); rd(4'h8, d); chk("R9 prescaler reloaded", d, 0);
    tick(1); rd(4'h8, d); chk("R9 first event after reload", d, 1);
    rd(4'hC, d);

    // R6 interrupt
    wr(4'h4, 32'hFFFFFFFF);
    wr(4'h0, 32'h00060001);
    #1 chk("R6 irq idle", {31'b0, irq}, 0);
    tick(1); #1 chk("R6 irq inc", {31'b0, irq}, 1);
    rd(4'hC, d); chk("R6 status", d, 2);
    #1 chk("R7 irq dropped", {31'b0, irq}, 0);
    wr(4'h0, 32'h00010001);
    tick(1); #1 chk("R6 inc masked", {31'b0, irq}, 0);
    rd(4'hC, d);
    wr(4'h4, 32'h2);
    tick(1); #1 chk("R6 irq alarm", {31'b0, irq}, 1);
    rd(4'hC, d); chk("R5 alarm flags", d, 3);

    // R8 event and read in the same cycle
    @(negedge clk);
    rdEn = 1; addr = 4'hC; slowTick = 1;
    #1 d = rdata;
    @(negedge clk);
    rdEn = 0; slowTick = 0;
    chk("R8 read returns old", d, 0);
    rd(4'hC, d); chk("R8 event kept", d, 2);

    // R10 divisor zero = 65536
    wr(4'h0, 32'h00040000);
    tick(65535); rd(4'h8, d); chk("R10 before 65536", d, 0);
    tick(1); rd(4'h8, d); chk("R10 at 65536", d, 1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule